// File: doc/BRIEF.md
# Fault-First Vector Load/Store Sequencer

This block walks a vector memory operation through its elements one at a time, from index 0 up to the requested vector length minus one. For each element it raises one memory request that carries the element index and the element address. The memory side answers each request with a response strobe and a fault bit. Only one element is in flight at any time.

In fault-first mode, element 0 behaves like an ordinary scalar access: if it faults, the exception is reported. A fault on any later element counts as speculative. The block then reports no exception and shortens the vector length to the number of elements that completed before the fault. Indexed addressing is not allowed in this mode, and that selector code means element-strided instead. Two options can shorten fault-first operations further:

- a minimum-compliance switch that performs element 0 only;
- an alignment switch that stops at the point where the next access would enter a new aligned block.

Fault-first combined with vertical-first stepping is rejected as unsupported.

When an operation ends, a one-cycle done pulse is given. The final length, the exception flag with the faulting address and index, and the unsupported flag all stay on the outputs until the next accepted start.

Top module: `ffvec_ldst_seq`

## Requirements
- R1: While reset is held, and after it, the outputs are idle: req_valid, busy, done, exc and unsup are 0, and vl_out is 0.
- R2: addr_sel selects the addressing mode. 00 is unit stride: element i goes to base_addr + i*elem_bytes. 01 is element-strided: base_addr + i*stride. 1x is indexed: base_addr + idx_off, where idx_off is sampled while that element is requested. Elements are requested in ascending index order starting at 0.
- R3: Only one request is outstanding at a time. The request stays asserted with a stable index until a response arrives. The next element is requested only after a response without fault. After vl_in elements have completed without fault, done pulses with vl_out = vl_in and exc = 0.
- R4: Outside fault-first mode, a fault on any element sets exc, exc_addr and exc_idx for that element and leaves vl_out equal to vl_in. No further requests are made.
- R5: In fault-first mode, a fault on element 0 is handled as in R4.
- R6: In fault-first mode, a fault on element i ≥ 1 sets vl_out = i, which is never zero, and leaves exc at 0. No further requests are made.
- R7: In fault-first mode, addr_sel = 1x uses element-strided addressing.
- R8: With min_ff set in fault-first mode, only element 0 is requested. On success vl_out = 1. On a fault, R5 applies.
- R9: With align_en set in fault-first mode, a successful element i whose successor address falls in a different 2^ALIGN_LG-byte block ends the operation with vl_out = i+1. Without fault-first mode, align_en has no effect.
- R10: A start with both ff_mode and vert_mode set makes no requests. done rises in the next cycle with unsup = 1, exc = 0 and vl_out = vl_in.
- R11: A start while busy is ignored. done lasts one cycle. The results hold until the next accepted start.
- R12: A start with vl_in = 0 makes no requests and gives done in the next cycle with vl_out = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted when not busy |
| ff_mode | input | 1 | Fault-first mode |
| vert_mode | input | 1 | Vertical-first stepping active |
| addr_sel | input | 2 | Addressing mode code (see R2) |
| min_ff | input | 1 | Minimum-compliance fault-first option |
| align_en | input | 1 | Alignment truncation option |
| vl_in | input | VL_W | Requested vector length |
| base_addr | input | AW | Base address |
| stride | input | AW | Element stride in bytes |
| elem_bytes | input | 8 | Element size in bytes |
| idx_off | input | AW | Offset for the current element in indexed mode |
| req_valid | output | 1 | Memory request present |
| req_idx | output | VL_W | Element index of the request |
| req_addr | output | AW | Element address of the request |
| rsp_valid | input | 1 | Response strobe for the current request |
| rsp_fault | input | 1 | Response reports a fault |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VL_W | Resulting vector length |
| exc | output | 1 | Exception raised |
| exc_addr | output | AW | Faulting address |
| exc_idx | output | VL_W | Faulting element index |
| unsup | output | 1 | Fault-first with vertical-first rejected |

## Verification
Two pairs of events can land in the same cycle. In the first, the final response and a new start pulse arrive together. The bench forces zero response latency and raises start on exactly the cycle where the last element is answered. It then expects the original length in vl_out and no new request in the cycle after done. In the second, a successful response coincides with an alignment block change. This is provoked with a unit-stride run that begins part-way into a block, and it is judged by the truncated length agreeing with the bench's own address walk.

// File: rtl/ffseq_pkg.sv
package ffseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FIN   = 2'd2
  } seq_st_t;

  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2
  } amode_t;

  // indexed selection is refused under fault-first and becomes strided
  function automatic amode_t resolve_mode(input logic ff, input logic [1:0] sel);
    if (sel[1]) return ff ? AM_STRIDE : AM_INDEX;
    return sel[0] ? AM_STRIDE : AM_UNIT;
  endfunction

  // true when two addresses lie in different 2^lg byte blocks
  function automatic logic blk_change(input logic [63:0] a, input logic [63:0] b,
                                      input int unsigned lg);
    return (a >> lg) != (b >> lg);
  endfunction

endpackage

// File: rtl/ffseq_agen.sv
module ffseq_agen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] cur,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] step_q;

  assign nxt = cur + step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      step_q <= '0;
    end else if (load) begin
      cur    <= base;
      step_q <= step;
    end else if (adv) begin
      cur    <= nxt;
    end
  end
endmodule

// File: rtl/ffseq_ctrl.sv
module ffseq_ctrl
  import ffseq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ff_mode,
  input  logic            vert_mode,
  input  logic            min_ff,
  input  logic            align_en,
  input  logic [VL_W-1:0] vl_in,
  input  logic            rsp_valid,
  input  logic            rsp_fault,
  input  logic            cross_next,
  input  logic [AW-1:0]   cur_addr,
  output logic            accept,
  output logic            advance,
  output logic            busy,
  output logic            done,
  output logic [VL_W-1:0] idx,
  output logic [VL_W-1:0] vl_out,
  output logic            exc,
  output logic            unsup,
  output logic [AW-1:0]   exc_addr,
  output logic [VL_W-1:0] exc_idx,
  output logic            ev_trap,
  output logic            ev_cut,
  output logic            ev_last,
  output logic            ev_align
);
  seq_st_t         state;
  logic            ff_q, align_q;
  logic [VL_W-1:0] last_q;
  logic            resp_ok, resp_bad, no_work, finish;

  assign busy     = (state == ST_ISSUE);
  assign done     = (state == ST_FIN);
  assign accept   = start && !busy;
  assign no_work  = (ff_mode && vert_mode) || (vl_in == '0);

  assign resp_ok  = busy && rsp_valid && !rsp_fault;
  assign resp_bad = busy && rsp_valid && rsp_fault;
  assign ev_trap  = resp_bad && (!ff_q || idx == '0);
  assign ev_cut   = resp_bad && ff_q && idx != '0;
  assign ev_last  = resp_ok && ((idx + VL_W'(1)) == last_q);
  assign ev_align = resp_ok && !ev_last && ff_q && align_q && cross_next;
  assign advance  = resp_ok && !ev_last && !ev_align;
  assign finish   = ev_trap || ev_cut || ev_last || ev_align;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      ff_q     <= 1'b0;
      align_q  <= 1'b0;
      last_q   <= '0;
      idx      <= '0;
      vl_out   <= '0;
      exc      <= 1'b0;
      unsup    <= 1'b0;
      exc_addr <= '0;
      exc_idx  <= '0;
    end else if (accept) begin
      state    <= no_work ? ST_FIN : ST_ISSUE;
      ff_q     <= ff_mode;
      align_q  <= align_en;
      last_q   <= (ff_mode && min_ff) ? VL_W'(1) : vl_in;
      idx      <= '0;
      vl_out   <= vl_in;
      exc      <= 1'b0;
      unsup    <= ff_mode && vert_mode;
    end else begin
      if (busy && finish) state <= ST_FIN;
      else if (done)      state <= ST_IDLE;
      if (advance) idx <= idx + VL_W'(1);
      if (ev_cut)   vl_out <= idx;
      if (ev_last)  vl_out <= last_q;
      if (ev_align) vl_out <= idx + VL_W'(1);
      if (ev_trap) begin
        exc      <= 1'b1;
        exc_addr <= cur_addr;
        exc_idx  <= idx;
      end
    end
  end
endmodule

// File: rtl/ffvec_ldst_seq.sv
module ffvec_ldst_seq
  import ffseq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int VL_W     = 7,
  parameter int ALIGN_LG = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ff_mode,
  input  logic            vert_mode,
  input  logic [1:0]      addr_sel,
  input  logic            min_ff,
  input  logic            align_en,
  input  logic [VL_W-1:0] vl_in,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   stride,
  input  logic [7:0]      elem_bytes,
  input  logic [AW-1:0]   idx_off,
  output logic            req_valid,
  output logic [VL_W-1:0] req_idx,
  output logic [AW-1:0]   req_addr,
  input  logic            rsp_valid,
  input  logic            rsp_fault,
  output logic            busy,
  output logic            done,
  output logic [VL_W-1:0] vl_out,
  output logic            exc,
  output logic [AW-1:0]   exc_addr,
  output logic [VL_W-1:0] exc_idx,
  output logic            unsup
);
  amode_t        mode_now, mode_q;
  logic [AW-1:0] step_now, run_addr, run_next;
  logic          accept, advance, cross_next;
  logic          ev_trap, ev_cut, ev_last, ev_align;

  assign mode_now = resolve_mode(ff_mode, addr_sel);

  // indexed mode holds the running address at base (step 0)
  always_comb begin
    unique case (mode_now)
      AM_UNIT:   step_now = AW'(elem_bytes);
      AM_STRIDE: step_now = stride;
      default:   step_now = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= AM_UNIT;
    else if (accept) mode_q <= mode_now;
  end

  ffseq_agen #(.AW(AW)) u_agen (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept),
    .adv  (advance),
    .base (base_addr),
    .step (step_now),
    .cur  (run_addr),
    .nxt  (run_next)
  );

  assign req_addr   = (mode_q == AM_INDEX) ? run_addr + idx_off : run_addr;
  assign cross_next = blk_change(64'(run_addr), 64'(run_next), ALIGN_LG);
  assign req_valid  = busy;

  ffseq_ctrl #(.AW(AW), .VL_W(VL_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ff_mode   (ff_mode),
    .vert_mode (vert_mode),
    .min_ff    (min_ff),
    .align_en  (align_en),
    .vl_in     (vl_in),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .cross_next(cross_next),
    .cur_addr  (req_addr),
    .accept    (accept),
    .advance   (advance),
    .busy      (busy),
    .done      (done),
    .idx       (req_idx),
    .vl_out    (vl_out),
    .exc       (exc),
    .unsup     (unsup),
    .exc_addr  (exc_addr),
    .exc_idx   (exc_idx),
    .ev_trap   (ev_trap),
    .ev_cut    (ev_cut),
    .ev_last   (ev_last),
    .ev_align  (ev_align)
  );
endmodule

// File: rtl/ffseq_chk.sv
module ffseq_chk #(
  parameter int AW   = 32,
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            ff_mode,
  input logic            vert_mode,
  input logic            busy,
  input logic            done,
  input logic            req_valid,
  input logic [VL_W-1:0] req_idx,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [VL_W-1:0] vl_out,
  input logic            exc,
  input logic [AW-1:0]   exc_addr,
  input logic            unsup,
  input logic            ev_trap,
  input logic            ev_cut
);
  AST_WAIT_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rsp_valid |=> busy && $stable(req_idx)); // R3
  AST_FAULT_ENDS_REQS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_valid && rsp_fault |=> !req_valid && done); // R4
  AST_TRAP_KEEPS_VL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> exc && $stable(vl_out)); // R4
  AST_ELEM0_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rsp_valid && rsp_fault && req_idx == '0 |=> exc); // R5
  AST_CUT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cut |=> vl_out != '0 && !exc); // R6
  AST_UNSUP_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && ff_mode && vert_mode |=> unsup && done && !req_valid); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !done && !start |=> $stable(vl_out) && $stable(exc) && $stable(exc_addr) && $stable(unsup)); // R11
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !rsp_valid |=> busy && $stable(req_idx)); // R11
endmodule

bind ffvec_ldst_seq ffseq_chk #(.AW(AW), .VL_W(VL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ff_mode  (ff_mode),
  .vert_mode(vert_mode),
  .busy     (busy),
  .done     (done),
  .req_valid(req_valid),
  .req_idx  (req_idx),
  .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault),
  .vl_out   (vl_out),
  .exc      (exc),
  .exc_addr (exc_addr),
  .unsup    (unsup),
  .ev_trap  (ev_trap),
  .ev_cut   (ev_cut)
);

// File: tb/test_ffvec_ldst_seq.sv
module test_ffvec_ldst_seq;
  localparam int AW = 32, VL_W = 7, ALIGN_LG = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, ff_mode = 1'b0, vert_mode = 1'b0;
  logic [1:0] addr_sel = 2'b00;
  logic min_ff = 1'b0, align_en = 1'b0;
  logic [VL_W-1:0] vl_in = '0;
  logic [AW-1:0] base_addr = '0, stride = '0, idx_off;
  logic [7:0] elem_bytes = 8'd4;
  logic req_valid, busy, done, exc, unsup;
  logic [VL_W-1:0] req_idx, vl_out, exc_idx;
  logic [AW-1:0] req_addr, exc_addr;
  logic rsp_valid = 1'b0, rsp_fault = 1'b0;

  ffvec_ldst_seq #(.AW(AW), .VL_W(VL_W), .ALIGN_LG(ALIGN_LG)) i_ffvec_ldst_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ff_mode(ff_mode), .vert_mode(vert_mode),
    .addr_sel(addr_sel), .min_ff(min_ff), .align_en(align_en), .vl_in(vl_in),
    .base_addr(base_addr), .stride(stride), .elem_bytes(elem_bytes), .idx_off(idx_off),
    .req_valid(req_valid), .req_idx(req_idx), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .busy(busy), .done(done),
    .vl_out(vl_out), .exc(exc), .exc_addr(exc_addr), .exc_idx(exc_idx), .unsup(unsup));

  int errs = 0, checks = 0, cyc = 0;
  int fault_at = -1, lat_seed = 0, seen = 0, wait_cnt = 0;
  bit lat_zero = 1'b0, mon_on = 1'b0;
  logic [AW-1:0] exp_addr [128];
  int exp_nreq, exp_vl, exp_eidx;
  bit exp_exc, exp_unsup;
  logic [AW-1:0] exp_eaddr;

  function automatic logic [AW-1:0] off_of(input int i);
    return AW'(i * 24 + 4);
  endfunction

  always_comb idx_off = off_of(int'(req_idx));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  // memory responder plus per-cycle request comparison
  always @(negedge clk) begin
    if (req_valid) begin
      if (mon_on)
        chk(int'(req_idx) < exp_nreq && req_addr == exp_addr[req_idx], "R2 request address",
            64'(req_addr), (int'(req_idx) < exp_nreq) ? 64'(exp_addr[req_idx]) : 64'hffff_ffff);
      if (wait_cnt >= (lat_zero ? 0 : (int'(req_idx) + lat_seed) % 3)) begin
        rsp_valid = 1'b1;
        rsp_fault = (int'(req_idx) == fault_at);
        wait_cnt  = 0;
        seen++;
      end else begin
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        wait_cnt++;
      end
    end else begin
      rsp_valid = 1'b0;
      rsp_fault = 1'b0;
      wait_cnt  = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errs++; checks++;
      $display("FAIL R3 watchdog actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // behavioural expectation: walk the elements the way the requirements describe
  task automatic model(input bit ff, input bit vt, input logic [1:0] sel, input bit mf, input bit al,
                       input int vl, input logic [AW-1:0] b, input int eb, input logic [AW-1:0] st,
                       input int flt);
    int n;
    logic [AW-1:0] a, an;
    exp_nreq = 0; exp_vl = vl; exp_exc = 0; exp_unsup = 0; exp_eaddr = '0; exp_eidx = 0;
    if (ff && vt) begin exp_unsup = 1; return; end
    n = (ff && mf) ? 1 : vl;
    for (int i = 0; i < n; i++) begin
      if (sel == 2'b00)     begin a = b + AW'(i * eb); an = a + AW'(eb); end
      else if (sel[1] && !ff) begin a = b + off_of(i); an = a; end
      else                  begin a = b + AW'(i) * st; an = a + st; end
      exp_addr[i] = a;
      exp_nreq++;
      if (i == flt) begin
        if (ff && i > 0) exp_vl = i;
        else begin exp_exc = 1; exp_eaddr = a; exp_eidx = i; end
        return;
      end
      if (i == n - 1) begin exp_vl = n; return; end
      if (ff && al && ((a >> ALIGN_LG) != (an >> ALIGN_LG))) begin exp_vl = i + 1; return; end
    end
  endtask

  task automatic run_op(input string tag, input bit ff, input bit vt, input logic [1:0] sel,
                        input bit mf, input bit al, input int vl, input logic [AW-1:0] b,
                        input int eb, input logic [AW-1:0] st, input int flt, input bit poke);
    int n;
    bit poked;
    model(ff, vt, sel, mf, al, vl, b, eb, st, flt);
    fault_at = flt; lat_zero = poke; lat_seed++;
    @(negedge clk);
    seen = 0;
    ff_mode = ff; vert_mode = vt; addr_sel = sel; min_ff = mf; align_en = al;
    vl_in = VL_W'(vl); base_addr = b; elem_bytes = 8'(eb); stride = st;
    start = 1'b1; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; poked = 0;
    while (!done && n < 500) begin
      if (poke && !poked && req_valid && int'(req_idx) == exp_nreq - 1) begin
        start = 1'b1; vl_in = VL_W'(3); poked = 1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n < 500, {tag, " done reached"}, 64'(n), 64'(500));
    chk(vl_out == VL_W'(exp_vl), {tag, " vl_out"}, 64'(vl_out), 64'(exp_vl));
    chk(exc == exp_exc, {tag, " exc"}, 64'(exc), 64'(exp_exc));
    chk(unsup == exp_unsup, {tag, " unsup"}, 64'(unsup), 64'(exp_unsup));
    chk(seen == exp_nreq, {tag, " request count"}, 64'(seen), 64'(exp_nreq));
    if (exp_exc) begin
      chk(exc_addr == exp_eaddr, {tag, " exc_addr"}, 64'(exc_addr), 64'(exp_eaddr));
      chk(int'(exc_idx) == exp_eidx, {tag, " exc_idx"}, 64'(exc_idx), 64'(exp_eidx));
    end
    @(negedge clk);
    chk(!done && !busy && !req_valid, "R11 done one cycle, no new op", {61'd0, done, busy, req_valid}, 64'd0);
    chk(vl_out == VL_W'(exp_vl), "R11 result held", 64'(vl_out), 64'(exp_vl));
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_valid && !busy && !done && !exc && !unsup && vl_out == '0, "R1 reset state",
        {59'd0, req_valid, busy, done, exc, unsup}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !busy && !done && vl_out == '0, "R1 idle after reset",
        {61'd0, req_valid, busy, done}, 64'd0);

    run_op("R3 unit full",        0, 0, 2'b00, 0, 0, 5,  32'h1000, 4, 0,     -1, 0);
    run_op("R2 strided",          0, 0, 2'b01, 0, 0, 4,  32'h2000, 4, 32'h30, -1, 0);
    run_op("R2 indexed",          0, 0, 2'b10, 0, 0, 4,  32'h3000, 4, 0,     -1, 0);
    run_op("R4 plain fault",      0, 0, 2'b00, 0, 0, 6,  32'h4000, 8, 0,      2, 0);
    run_op("R5 ff elem0 fault",   1, 0, 2'b00, 0, 0, 6,  32'h5000, 4, 0,      0, 0);
    run_op("R6 ff later fault",   1, 0, 2'b01, 0, 0, 8,  32'h6000, 4, 32'h20, 3, 0);
    run_op("R6 ff fault elem1",   1, 0, 2'b00, 0, 0, 4,  32'h6800, 4, 0,      1, 0);
    run_op("R7 ff index->stride", 1, 0, 2'b11, 0, 0, 3,  32'h7000, 4, 32'h10, -1, 0);
    run_op("R8 min ff ok",        1, 0, 2'b00, 1, 0, 7,  32'h8000, 4, 0,     -1, 0);
    run_op("R8 min ff fault",     1, 0, 2'b00, 1, 0, 7,  32'h8100, 4, 0,      0, 0);
    run_op("R9 align cut",        1, 0, 2'b00, 0, 1, 10, 32'h1028, 8, 0,     -1, 0);
    run_op("R9 align no ff",      0, 0, 2'b00, 0, 1, 10, 32'h1028, 8, 0,     -1, 0);
    run_op("R10 vert unsup",      1, 1, 2'b00, 0, 0, 5,  32'h9000, 4, 0,     -1, 0);
    run_op("R12 empty",           0, 0, 2'b00, 0, 0, 0,  32'ha000, 4, 0,     -1, 0);
    run_op("R11 start while busy",0, 0, 2'b00, 0, 0, 4,  32'hb000, 4, 0,     -1, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule